// File: doc/BRIEF.md
# Clock-Synchronous Byte Serial Port

This block is a full-duplex serial port that moves one byte per transfer over a clock and two data lines. One shift register is used for both directions. Software writes the byte to send, and that write starts the transfer. Each bit taken from the serial input enters the register as a bit leaves it. When the transfer is done, the register holds the received byte. There is no second buffer, so writing during a transfer corrupts the byte in flight.

The transfer clock comes from one of two places. The block can make it by dividing a prescaler strobe by an 8-bit divider. It can also take it from the clock pin, through a two-flop synchronizer and edge detector, so that all shifting happens in the system clock domain. Software chooses the bit order, the clock polarity, and the level the data output rests at between transfers in external-clock mode. In internal-clock mode the data output keeps its last bit for half a clock period and then releases the line. A single-cycle interrupt pulse marks the final clock edge.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the port is in internal-clock mode with the clock output enabled and resting high. The data output is released (`sdo_oe`=0), `irq` is 0, `rd_data` is 0 and the divider is 0.
- R2: In internal-clock mode, writing address 0 (data) starts a transfer of exactly 8 clock pulses, or 16 edges. The clock then stops at its rest level, which is high when the polarity bit is 0 and low when it is 1.
- R3: In internal-clock mode, every half period of the generated clock lasts (div+1) prescaler strobes. The divider is written at address 2.
- R4: Control bit 1 at address 1 selects the bit order. With 0, bit 0 is sent first and the first received bit lands in bit 0. With 1, bit 7 goes first and the first received bit lands in bit 7. The received byte is on `rd_data` once `irq` has pulsed.
- R5: Control bit 2 selects the polarity. With 0, data is launched on falling edges and sampled on rising edges. With 1, the two edges swap. The first edge of a transfer is always a launch edge.
- R6: `irq` is high for exactly one cycle per transfer. In internal-clock mode it rises in the same cycle as the last sampling edge on `sclk_out`.
- R7: In internal-clock mode, `sdo_oe` rises at the first launch edge. After the last sampling edge, `sdo` holds the final bit for (div+1) strobe periods, and then `sdo_oe` falls.
- R8: In internal-clock mode, a data write during the hold window clears `sdo_oe` in the next cycle.
- R9: With control bit 0 set (external clock), `sclk_oe` is 0. Data is launched and sampled on the synchronized edges of `sclk_in`, following R4 and R5, and `irq` pulses after the eighth sampling edge.
- R10: In external-clock mode, `sdo_oe` is 1 at all times. Between transfers `sdo` drives the level written in control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_tick | input | 1 | Prescaler strobe; the internal divider counts it |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 = data (starts transfer), 1 = control, 2 = divider |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Shift register contents (received byte) |
| sclk_in | input | 1 | External transfer clock |
| sclk_out | output | 1 | Generated transfer clock |
| sclk_oe | output | 1 | Clock pin drive enable (internal mode) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data out drive enable |
| irq | output | 1 | Transfer-complete pulse |

## Verification
The bench sweeps both bit orders and both polarities over several divider values and data patterns. For every bit it checks the launch and sampling edge positions and the edge spacing. A port that sampled on the launch edge would capture the previous input bit. A wrong half period, or a pulse count that is off by one edge, shows up as a wrong edge gap or as a clock left away from its rest level. The hold window is timed cycle by cycle: a hold one strobe too short or too long fails R7. The bench also writes inside the hold window, which catches a port that keeps driving the old bit. External-mode runs check the idle level before and after the transfer, so a port that drives the last data bit instead of the programmed level is caught.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd1;
  localparam logic [ADDR_W-1:0] A_DIV  = 2'd2;

  typedef struct packed {
    logic idle_lvl;   // bit 3: rest level of sdo, external mode
    logic pol;        // bit 2: 1 = launch on rising edge
    logic msb_first;  // bit 1: bit order
    logic ext_clk;    // bit 0: 1 = clock from pin
  } ssp_ctrl_t;

  localparam int CTRL_W = $bits(ssp_ctrl_t);
endpackage

// File: rtl/ssp_baud.sv
module ssp_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [DIV_W-1:0] div,
  output logic             stb
);
  logic [DIV_W-1:0] cnt_q;

  assign stb = run && tick && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (cnt_q == div) cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ssp_edge_sync.sv
module ssp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] && !last_q;
  assign fall = !sync_q[STAGES-1] && last_q;
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         msb_first,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q,
  output logic         dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= load_val;
    end else if (shift) begin
      if (msb_first) q <= {q[W-2:0], din};
      else           q <= {din, q[W-1:1]};
    end
  end

  assign dout = msb_first ? q[W-1] : q[0];
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              presc_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              irq
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  ssp_ctrl_t        ctrl_q;
  logic [DIV_W-1:0] div_q;
  logic             busy_q, hold_q, clk_lvl_q, sdo_q, oe_q, irq_q;
  logic [CNT_W-1:0] bit_cnt_q;

  logic start, stb, ext_rise, ext_fall, launch_ev, sample_ev, last_ev;
  logic shift_out;
  logic ext_mode, pol_sel;

  assign ext_mode = ctrl_q.ext_clk;
  assign pol_sel  = ctrl_q.pol;
  assign start    = wr_en && (wr_addr == A_DATA);

  ssp_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst),
    .run((busy_q && !ext_mode) || hold_q),
    .restart(start), .tick(presc_tick), .div(div_q), .stb(stb)
  );

  ssp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(sclk_in), .rise(ext_rise), .fall(ext_fall)
  );

  // Leaving the rest level launches; returning to it samples.
  always_comb begin
    if (ext_mode) begin
      launch_ev = busy_q && (pol_sel ? ext_rise : ext_fall);
      sample_ev = busy_q && (pol_sel ? ext_fall : ext_rise);
    end else begin
      launch_ev = busy_q && stb && (clk_lvl_q == !pol_sel);
      sample_ev = busy_q && stb && (clk_lvl_q == pol_sel);
    end
  end
  assign last_ev = sample_ev && (bit_cnt_q == LAST_BIT);

  ssp_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(start), .load_val(wr_data),
    .msb_first(ctrl_q.msb_first), .shift(sample_ev), .din(sdi),
    .q(rd_data), .dout(shift_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      div_q     <= '0;
      busy_q    <= 1'b0;
      hold_q    <= 1'b0;
      bit_cnt_q <= '0;
      clk_lvl_q <= 1'b1;
      sdo_q     <= 1'b0;
      oe_q      <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= last_ev;
      if (wr_en && wr_addr == A_CTRL) ctrl_q <= ssp_ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_en && wr_addr == A_DIV)  div_q  <= wr_data[DIV_W-1:0];

      if (start) begin
        busy_q    <= 1'b1;
        hold_q    <= 1'b0;
        bit_cnt_q <= '0;
      end else if (sample_ev) begin
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (last_ev) begin
          busy_q <= 1'b0;
          hold_q <= !ext_mode;
        end
      end else if (hold_q && stb) begin
        hold_q <= 1'b0;
      end

      if (!busy_q)                clk_lvl_q <= !pol_sel;
      else if (!ext_mode && stb)  clk_lvl_q <= !clk_lvl_q;

      if (start)          sdo_q <= ctrl_q.msb_first ? wr_data[DATA_W-1] : wr_data[0];
      else if (launch_ev) sdo_q <= shift_out;

      if (start)                oe_q <= 1'b0;
      else if (launch_ev)       oe_q <= 1'b1;
      else if (hold_q && stb)   oe_q <= 1'b0;
    end
  end

  assign sclk_out = clk_lvl_q;
  assign sclk_oe  = !ext_mode;
  assign sdo      = (ext_mode && !busy_q) ? ctrl_q.idle_lvl : sdo_q;
  assign sdo_oe   = ext_mode ? 1'b1 : oe_q;
  assign irq      = irq_q;
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk
  import ssp_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic              busy,
  input logic              ext,
  input logic              pol,
  input logic              sclk_out,
  input logic              sclk_oe,
  input logic              sdo_oe,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr
);
  // R6
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R6
  irq_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(busy) && !busy));

  // R2
  sclk_rest_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_oe && !busy && !$past(busy) && $stable(pol)) |-> (sclk_out == !pol));

  // R8
  hold_cut_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_DATA && !ext) |=> !sdo_oe);
endmodule

bind sync_serial_port ssp_chk u_chk (
  .clk(clk), .rst(rst), .irq(irq), .busy(busy_q), .ext(ext_mode),
  .pol(pol_sel), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdo_oe(sdo_oe),
  .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/sim_sync_serial_port.sv
`timescale 1ns/1ps
module sim_sync_serial_port;
  localparam int TP   = 2;
  localparam int HALF = 6;

  logic clk = 1'b0, rst = 1'b1, presc_tick = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic sclk_in = 1'b1, sclk_out, sclk_oe, sdi = 1'b0, sdo, sdo_oe, irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sync_serial_port u0 (
    .clk(clk), .rst(rst), .presc_tick(presc_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_data(rd_data),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .irq(irq)
  );

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      presc_tick = (tc == TP - 1);
      tc = (tc + 1) % TP;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_int(input logic [7:0] tx, input logic [7:0] rx, input bit msb,
                         input bit pol, input int dv, input bit cut);
    int edges = 0, samples = 0, irqs = 0, cyc = 0, last_cyc = 0, c = 0;
    bit held = 1;
    logic prev, exp_bit, last_bit;
    wr(2'd1, {4'b0, 1'b0, pol, msb, 1'b0});
    wr(2'd2, 8'(dv));
    repeat (3) @(negedge clk);
    chk(sclk_out == !pol, "R2 rest level before", sclk_out, !pol);
    wr(2'd0, tx);
    chk(sdo_oe == 1'b0, "R7 released before first launch", sdo_oe, 0);
    prev = sclk_out;
    while (samples < 8 && cyc < 5000) begin
      @(negedge clk); cyc++;
      if (irq) irqs++;
      if (sclk_out != prev) begin
        edges++;
        if (edges == 1) chk(sclk_out == pol, "R5 first edge is launch", sclk_out, pol);
        if (edges == 2) chk(cyc - last_cyc == (dv + 1) * TP, "R3 half period", cyc - last_cyc, (dv + 1) * TP);
        last_cyc = cyc;
        if (sclk_out == pol) begin
          sdi = msb ? rx[7 - samples] : rx[samples];
          if (samples == 0) chk(sdo_oe == 1'b1, "R7 drive at first launch", sdo_oe, 1);
        end else begin
          exp_bit = msb ? tx[7 - samples] : tx[samples];
          chk(sdo == exp_bit, "R4 R5 tx bit", sdo, exp_bit);
          samples++;
          if (samples == 8) chk(irq == 1'b1, "R6 irq with last sample edge", irq, 1);
        end
        prev = sclk_out;
      end
    end
    chk(samples == 8, "R2 transfer completes", samples, 8);
    if (cut) begin
      @(negedge clk);
      chk(sdo_oe == 1'b1, "R7 drive in hold", sdo_oe, 1);
      wr(2'd0, ~tx);
      chk(sdo_oe == 1'b0, "R8 write in hold releases", sdo_oe, 0);
      c = 0;
      while (!irq && c < 5000) begin @(negedge clk); c++; end
      while (sdo_oe && c < 5000) begin @(negedge clk); c++; end
      repeat (4) @(negedge clk);
    end else begin
      last_bit = msb ? tx[0] : tx[7];
      while (sdo_oe && c < 5000) begin
        @(negedge clk); c++;
        if (irq) irqs++;
        if (sdo_oe && sdo != last_bit) held = 0;
      end
      chk(c == (dv + 1) * TP, "R7 hold length", c, (dv + 1) * TP);
      chk(held, "R7 last bit held", held, 1);
      repeat (2 * (dv + 1) * TP + 2) begin
        @(negedge clk);
        if (irq) irqs++;
        if (sclk_out != prev) begin edges++; prev = sclk_out; end
      end
      chk(edges == 16, "R2 pulse edges", edges, 16);
      chk(sclk_out == !pol, "R2 rest level after", sclk_out, !pol);
      chk(irqs == 1, "R6 one irq", irqs, 1);
      chk(rd_data == rx, "R4 rx byte", rd_data, rx);
    end
  endtask

  task automatic run_ext(input logic [7:0] tx, input logic [7:0] rx, input bit msb,
                         input bit pol, input bit idle);
    int irqs = 0;
    logic exp_bit;
    sclk_in = !pol;
    wr(2'd1, {4'b0, idle, pol, msb, 1'b1});
    repeat (6) @(negedge clk);
    chk(sclk_oe == 1'b0, "R9 clock pin released", sclk_oe, 0);
    chk(sdo_oe == 1'b1 && sdo == idle, "R10 idle level before", sdo, idle);
    wr(2'd0, tx);
    for (int k = 0; k < 8; k++) begin
      repeat (HALF) begin @(negedge clk); if (irq) irqs++; end
      sclk_in = pol;
      sdi = msb ? rx[7 - k] : rx[k];
      repeat (HALF) begin @(negedge clk); if (irq) irqs++; end
      exp_bit = msb ? tx[7 - k] : tx[k];
      chk(sdo == exp_bit, "R9 tx bit", sdo, exp_bit);
      sclk_in = !pol;
    end
    repeat (12) begin @(negedge clk); if (irq) irqs++; end
    chk(irqs == 1, "R9 R6 one irq", irqs, 1);
    chk(rd_data == rx, "R9 rx byte", rd_data, rx);
    chk(sdo_oe == 1'b1 && sdo == idle, "R10 idle level after", sdo, idle);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sclk_oe == 1'b1 && sclk_out == 1'b1, "R1 clock rests high", sclk_out, 1);
    chk(sdo_oe == 1'b0, "R1 data released", sdo_oe, 0);
    chk(irq == 1'b0, "R1 no irq", irq, 0);
    chk(rd_data == 8'h00, "R1 rd_data clear", rd_data, 0);
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 2; p++)
        for (int d = 0; d < 3; d++)
          for (int i = 0; i < 4; i++) begin
            logic [7:0] tx, rx;
            tx = 8'hA5 ^ 8'(i * 37 + d * 11);
            rx = {tx[3:0], ~tx[7:4]} ^ 8'(m * 16 + p);
            run_int(tx, rx, m[0], p[0], (d == 2) ? 3 : d, 1'b0);
          end
    run_int(8'h3C, 8'hC3, 1'b0, 1'b0, 3, 1'b1);
    run_int(8'h81, 8'h7E, 1'b1, 1'b1, 3, 1'b1);
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 2; p++)
        for (int l = 0; l < 2; l++)
          run_ext(8'h96 ^ 8'(m * 64 + p * 5 + l), 8'h1F ^ 8'(p * 128 + l * 3 + m), m[0], p[0], l[0]);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule